// File: doc/BRIEF.md
# History-Selected Two-Bit Direction Predictor

This block predicts whether a conditional branch will be taken. It holds four equal-sized tables of two-bit entries, all indexed by the word-address bits of the branch PC. A two-bit global history register remembers the directions of the two branches resolved most recently. That history picks the table that answers each lookup. Lookup is combinational: the fetch side presents a PC and receives a taken or not-taken answer. It also receives the history value that chose the table.

The fetch side carries that history value alongside the branch down the pipeline. When the branch resolves, the execute side presents the PC, the real direction and the carried history. The block writes the resolved direction into the table that the carried history selects, then shifts the direction into the global history. Each entry holds a prediction bit and a last-correct bit. A single surprise, such as a loop exit, therefore does not reverse the prediction.

Top module: `hsel_dir_predictor`

## Requirements
- R1: After reset the global history is 00. Every entry of every table then predicts not taken, with its last-correct bit set.
- R2: The history output lk_hist carries the older outcome in bit 1 and the newer outcome in bit 0. A cycle with up_valid high makes the next history {old bit 0, up_taken}.
- R3: Tables are numbered 0 to 3 by 2*newer + older. History 00 selects table 0, 10 selects table 1, 01 selects table 2 and 11 selects table 3. Training one table leaves the predictions read through the other histories unchanged.
- R4: The entry is chosen by lk_pc, which carries PC bits IDX_W+1 down to 2. Entries at different indices are independent.
- R5: A misprediction on an entry whose last-correct bit is 1 keeps the prediction and clears last-correct.
- R6: A misprediction on an entry whose last-correct bit is 0 inverts the prediction and sets last-correct.
- R7: A correct prediction keeps the prediction and sets last-correct. A later single miss therefore does not flip the entry.
- R8: An update writes the table selected by up_hist, not the one selected by the current history.
- R9: While up_valid is low, up_pc, up_taken and up_hist have no effect. Neither the history nor any entry changes.
- R10: lk_taken follows lk_pc and the history in the same cycle. In a cycle that updates the looked-up entry it shows the old value, and it shows the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | IDX_W | Lookup PC bits [IDX_W+1:2] |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | 2 | Current global history, to travel with the branch |
| up_valid | input | 1 | A branch resolves this cycle |
| up_pc | input | IDX_W | Resolved branch PC bits [IDX_W+1:2] |
| up_taken | input | 1 | Resolved direction |
| up_hist | input | 2 | History captured at that branch's lookup |

## Verification
The bench builds the block with IDX_W = 4, which gives sixteen entries per table. With tables that small, a few thousand random resolutions revisit every entry of every table under all four history values many times. Directed sequences first place the history at each of the four codes and walk single entries through miss, hit and double-miss orders. Then the random phase updates entries through histories that differ from the current one. A bench-side model built from the requirements follows every step.

// File: rtl/hsel_pkg.sv
`timescale 1ns/1ps
package hsel_pkg;

  localparam int HIST_W  = 2;
  localparam int NUM_TBL = 4;

  typedef struct packed {
    logic pred;  // 1 = predict taken
    logic ok;    // last prediction was correct
  } hsel_ent_t;

  localparam hsel_ent_t ENT_RESET = '{pred: 1'b0, ok: 1'b1};

  // Entry next state after a branch resolves with direction outcome.
  function automatic hsel_ent_t hsel_ent_next(hsel_ent_t cur, logic outcome);
    hsel_ent_t nxt;
    nxt = cur;
    if (cur.pred == outcome) begin
      nxt.ok = 1'b1;
    end else if (cur.ok) begin
      nxt.ok = 1'b0;
    end else begin
      nxt.pred = ~cur.pred;
      nxt.ok   = 1'b1;
    end
    return nxt;
  endfunction

  // Table number = 2*newer + older; history bit 1 is older, bit 0 newer.
  function automatic logic [1:0] hsel_tbl_sel(logic [HIST_W-1:0] h);
    return {h[0], h[1]};
  endfunction

endpackage

// File: rtl/hsel_history.sv
`timescale 1ns/1ps
module hsel_history
  import hsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) begin
      hist_d = {hist_q[HIST_W-2:0], shift_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/hsel_bank.sv
`timescale 1ns/1ps
module hsel_bank
  import hsel_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_pred,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  hsel_ent_t ent_q [DEPTH];
  hsel_ent_t wr_cur;
  hsel_ent_t wr_nxt;

  always_comb begin
    wr_cur = ent_q[wr_idx];
    wr_nxt = hsel_ent_next(wr_cur, wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_q[i] <= ENT_RESET;
      end
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_nxt;
    end
  end

  assign rd_pred = ent_q[rd_idx].pred;

endmodule

// File: rtl/hsel_dir_predictor.sv
`timescale 1ns/1ps
module hsel_dir_predictor
  import hsel_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W+1:2]  lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [IDX_W+1:2]  up_pc,
  input  logic              up_taken,
  input  logic [HIST_W-1:0] up_hist
);

  logic [HIST_W-1:0]  hist;
  logic [1:0]         rd_sel;
  logic [1:0]         wr_sel;
  logic [NUM_TBL-1:0] bank_pred;
  logic [NUM_TBL-1:0] bank_wr;
  logic [IDX_W-1:0]   rd_idx;
  logic [IDX_W-1:0]   wr_idx;

  hsel_history u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (up_valid),
    .shift_bit (up_taken),
    .hist_o    (hist)
  );

  always_comb begin
    rd_idx = lk_pc;
    wr_idx = up_pc;
    rd_sel = hsel_tbl_sel(hist);
    wr_sel = hsel_tbl_sel(up_hist);
  end

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_bank
    assign bank_wr[g] = up_valid && (wr_sel == 2'(g));

    hsel_bank #(.IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_pred  (bank_pred[g]),
      .wr_en    (bank_wr[g]),
      .wr_idx   (wr_idx),
      .wr_taken (up_taken)
    );
  end

  assign lk_taken = bank_pred[rd_sel];
  assign lk_hist  = hist;

endmodule

// File: rtl/hsel_dir_predictor_chk.sv
`timescale 1ns/1ps
module hsel_dir_predictor_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W+1:2] lk_pc,
  input logic             lk_taken,
  input logic [1:0]       lk_hist,
  input logic             up_valid,
  input logic [IDX_W+1:2] up_pc,
  input logic             up_taken,
  input logic [1:0]       up_hist
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: first edge after reset release sees the reset state
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (lk_hist == 2'b00 && !lk_taken));

  // R2: history shifts in the resolved direction
  assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(up_valid)) |-> (lk_hist == {$past(lk_hist[0]), $past(up_taken)}));

  // R9: no resolution, no history change
  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(up_valid)) |-> $stable(lk_hist));

  // R9: no resolution, same PC, same answer
  assert_pred_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

  // R8: an update to another index of any table leaves this lookup alone when history is unchanged
  assert_other_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(up_valid) && $stable(lk_pc) && $stable(lk_hist) &&
     ($past(up_pc) != $past(lk_pc))) |-> $stable(lk_taken));

endmodule

bind hsel_dir_predictor hsel_dir_predictor_chk #(.IDX_W(IDX_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_pc    (lk_pc),
  .lk_taken (lk_taken),
  .lk_hist  (lk_hist),
  .up_valid (up_valid),
  .up_pc    (up_pc),
  .up_taken (up_taken),
  .up_hist  (up_hist)
);

// File: tb/hsel_dir_predictor_tb_top.sv
`timescale 1ns/1ps
module hsel_dir_predictor_tb_top;

  localparam int IW = 4;
  localparam int NE = 1 << IW;

  typedef struct {
    logic       taken;
    logic [1:0] hist;
    string      req;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic [IW+1:2] lk_pc;
  logic          lk_taken;
  logic [1:0]    lk_hist;
  logic          up_valid;
  logic [IW+1:2] up_pc;
  logic          up_taken;
  logic [1:0]    up_hist;

  int   n_chk;
  int   n_fail;
  exp_t sb_q[$];
  event mon_ev;

  // model state, from the requirements
  logic       m_pred [4][NE];
  logic       m_ok   [4][NE];
  logic [1:0] m_h;

  hsel_dir_predictor #(.IDX_W(IW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .lk_hist  (lk_hist),
    .up_valid (up_valid),
    .up_pc    (up_pc),
    .up_taken (up_taken),
    .up_hist  (up_hist)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [1:0] tsel(logic [1:0] h);
    return {h[0], h[1]};  // R3: 2*newer + older
  endfunction

  task automatic step(input logic [IW+1:2] pc, input logic uv, input logic [IW+1:2] upc,
                      input logic ut, input logic [1:0] uh, input string req);
    exp_t e;
    logic [1:0] s;
    @(negedge clk);
    lk_pc = pc; up_valid = uv; up_pc = upc; up_taken = ut; up_hist = uh;
    e.taken = m_pred[tsel(m_h)][pc];
    e.hist  = m_h;
    e.req   = req;
    sb_q.push_back(e);
    ->mon_ev;
    @(posedge clk);
    if (uv) begin
      s = tsel(uh);
      if (m_pred[s][upc] == ut)  m_ok[s][upc] = 1'b1;       // R7
      else if (m_ok[s][upc])     m_ok[s][upc] = 1'b0;       // R5
      else begin m_pred[s][upc] = ~m_pred[s][upc]; m_ok[s][upc] = 1'b1; end  // R6
      m_h = {m_h[0], ut};                                   // R2
    end
  endtask

  // two resolutions of a scratch entry (pc 9, table 3) to place the history
  task automatic set_hist(input logic [1:0] h);
    step(9, 1'b1, 9, h[1], 2'b11, "R2");
    step(9, 1'b1, 9, h[0], 2'b11, "R2");
  endtask

  task automatic look(input logic [IW+1:2] pc, input string req);
    step(pc, 1'b0, pc, 1'b1, ~m_h, req);
  endtask

  // monitor: pop and compare away from the clock edge
  initial begin
    exp_t e;
    forever begin
      @(mon_ev);
      #2;
      e = sb_q.pop_front();
      n_chk++;
      if (lk_taken !== e.taken) begin
        n_fail++;
        $display("FAIL %s: lk_taken actual %b expected %b (pc %0d)", e.req, lk_taken, e.taken, lk_pc);
      end
      n_chk++;
      if (lk_hist !== e.hist) begin
        n_fail++;
        $display("FAIL %s: lk_hist actual %b expected %b", e.req, lk_hist, e.hist);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; up_hist = '0;
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < NE; i++) begin m_pred[t][i] = 1'b0; m_ok[t][i] = 1'b1; end
    m_h = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across indices
    for (int i = 0; i < NE; i++) look(IW'(i), "R1");

    // R5: one miss from last-correct=1 keeps not-taken
    step(3, 1'b1, 3, 1'b1, 2'b00, "R10");
    set_hist(2'b00);
    look(3, "R5");
    // R6: second miss flips
    step(3, 1'b1, 3, 1'b1, 2'b00, "R6");
    set_hist(2'b00);
    look(3, "R6");

    // R7: miss, hit, miss leaves prediction
    step(5, 1'b1, 5, 1'b1, 2'b00, "R7");
    step(5, 1'b1, 5, 1'b0, 2'b00, "R7");
    step(5, 1'b1, 5, 1'b1, 2'b00, "R7");
    set_hist(2'b00);
    look(5, "R7");

    // R3: train pc 6 only in table 1 (history 10), read under all four histories
    step(6, 1'b1, 6, 1'b1, 2'b10, "R8");
    step(6, 1'b1, 6, 1'b1, 2'b10, "R8");
    for (int h = 0; h < 4; h++) begin
      set_hist(2'(h));
      look(6, "R3");
    end

    // R4: neighbouring indices unaffected
    set_hist(2'b10);
    look(6, "R4");
    look(7, "R4");
    look(14, "R4");

    // R8: update through a history unlike the current one
    set_hist(2'b11);
    step(7, 1'b1, 7, 1'b1, 2'b01, "R8");
    step(7, 1'b1, 7, 1'b1, 2'b01, "R8");
    set_hist(2'b01);
    look(7, "R8");
    set_hist(2'b11);
    look(7, "R8");

    // R9: idle inputs toggled without up_valid
    set_hist(2'b10);
    for (int i = 0; i < 6; i++) step(6, 1'b0, 6, i[0], 2'(i), "R9");
    look(6, "R9");

    // R10: update of the looked-up entry shows old value, then new
    set_hist(2'b00);
    step(2, 1'b1, 2, 1'b1, m_h, "R10");
    step(2, 1'b1, 2, 1'b1, 2'b00, "R10");
    set_hist(2'b00);
    look(2, "R10");

    // random mix
    for (int n = 0; n < 5000; n++) begin
      logic [IW+1:2] p;
      logic [1:0]    uh;
      p  = IW'($urandom_range(0, NE - 1));
      uh = ($urandom_range(0, 1) == 0) ? m_h : 2'($urandom_range(0, 3));
      step(p, 1'($urandom_range(0, 3) != 0), IW'($urandom_range(0, NE - 1)),
           1'($urandom_range(0, 1)), uh, "R3/R2");
    end

    @(negedge clk);
    #3;
    finish_run();
  end

endmodule